// File: doc/BRIEF.md
# Banked Nonvolatile Memory Select Decoder

This block sits between a processor's 20-bit address bus and four 32K x 8 nonvolatile memory devices. It places the four devices at the top 128 KB of the 1 MB space. Decoding happens in two steps. The first step is a qualifier that recognises the high region from the three most significant address bits. The second step is a 2-to-4 select that turns the next two address bits into one active-low chip select per device. The processor's read strobe is passed on as the shared output enable. The write strobe is passed on as the shared write enable.

Behavioural models of the four devices are built into the block. Each model drives its byte onto a shared 8-bit data path only when both its chip select and its output enable are active. A resolver merges the four device outputs. It raises a bus-valid flag when a device is driving and a contention flag when more than one device drives at the same time. The model contents are computed, not stored. An undriven bus is represented by a data value of zero with the valid flag low, rather than by high impedance.

Top module: `rom_bank_decode`

## Requirements
- R1: When address bits 19..17 are not all 1, every chip select (cs_n_o[3:0]) is high.
- R2: When address bits 19..17 are all 1, cs_n_o[k] is low for k equal to address bits 16..15, and the other three chip selects are high.
- R3: At most one chip select is low at any time.
- R4: oe_n_o always equals rd_n_i and we_n_o always equals wr_n_i, whatever the address.
- R5: dev_offset_o always equals address bits 14..0.
- R6: A device drives the data path only when its chip select and the output enable are both low. While one device drives, bus_valid_o is 1.
- R7: The byte read from device b at offset o is ((o[7:0] XOR {0,o[14:8]}) + 64*b) mod 256.
- R8: When no device drives, because the address is outside the high region or rd_n_i is high, bus_valid_o is 0 and bus_data_o is 8'h00.
- R9: A low write strobe with the read strobe high does not make any device drive; bus_valid_o stays 0.
- R10: contention_o is 1 only when two or more devices drive at once. Under legal decoding it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Processor address bus |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| cs_n_o | output | 4 | Per-device chip select, active low |
| oe_n_o | output | 1 | Shared output enable to the devices, active low |
| we_n_o | output | 1 | Shared write enable to the devices, active low |
| dev_offset_o | output | 15 | Offset inside the selected device |
| bus_data_o | output | 8 | Resolved data path value |
| bus_valid_o | output | 1 | A device is driving the data path |
| contention_o | output | 1 | Two or more devices drive together |

## Verification
The block holds no state, so a decode fault shows at the ports in the same settle interval as the address that causes it. A qualifier that accepts the wrong upper bits gives a low chip select and a valid byte for an address that should have read as idle. A bank select that uses the wrong bits or has the wrong polarity gives the wrong device's byte; the per-device term of 64*b in the content makes that visible. A gating fault in a device model shows either as a valid flag while the read strobe is high or as contention during a plain read.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;
    localparam int ADDR_W    = 20;
    localparam int DATA_W    = 8;
    localparam int HI_BITS   = 3;
    localparam int BANK_BITS = 2;
    localparam int OFF_W     = ADDR_W - HI_BITS - BANK_BITS;
    localparam int NBANK     = 1 << BANK_BITS;

    typedef logic [BANK_BITS-1:0] bank_t;
    typedef logic [OFF_W-1:0]     off_t;
    typedef logic [DATA_W-1:0]    byte_t;

    // Stored byte of a device as a function of its index and offset
    function automatic byte_t dev_pattern(input bank_t b, input off_t o);
        byte_t lo;
        byte_t hi;
        byte_t bofs;
        lo   = o[DATA_W-1:0];
        hi   = byte_t'(o[OFF_W-1:DATA_W]);
        bofs = {b, {(DATA_W-BANK_BITS){1'b0}}};
        return (lo ^ hi) + bofs;
    endfunction
endpackage

// File: rtl/rbd_hi_qual.sv
module rbd_hi_qual
    import rom_bank_pkg::*;
(
    input  logic [HI_BITS-1:0] top_bits_i,
    output logic               hi_ok_o
);
    always_comb begin
        hi_ok_o = &top_bits_i;
    end
endmodule

// File: rtl/rbd_bank_sel.sv
module rbd_bank_sel
    import rom_bank_pkg::*;
(
    input  logic             hi_ok_i,
    input  bank_t            bank_i,
    output logic [NBANK-1:0] cs_n_o
);
    for (genvar g = 0; g < NBANK; g++) begin : g_cs
        assign cs_n_o[g] = !(hi_ok_i && (bank_i == bank_t'(g)));
    end

    always_comb begin
        // R1
        hi_gate_chk: assert (hi_ok_i || (&cs_n_o))
            else $error("chip select active outside high region");
    end
endmodule

// File: rtl/rbd_device.sv
module rbd_device
    import rom_bank_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic  cs_n_i,
    input  logic  oe_n_i,
    input  off_t  off_i,
    output logic  drive_o,
    output byte_t data_o
);
    always_comb begin
        drive_o = !cs_n_i && !oe_n_i;
        data_o  = drive_o ? dev_pattern(bank_t'(BANK), off_i) : '0;
    end
endmodule

// File: rtl/rbd_bus_resolve.sv
module rbd_bus_resolve
    import rom_bank_pkg::*;
(
    input  logic [NBANK-1:0]             drive_i,
    input  logic [NBANK-1:0][DATA_W-1:0] data_i,
    output byte_t                        data_o,
    output logic                         valid_o,
    output logic                         contention_o
);
    always_comb begin
        data_o = '0;
        for (int k = 0; k < NBANK; k++) begin
            if (drive_i[k]) data_o = data_o | data_i[k];
        end
        valid_o      = |drive_i;
        contention_o = $countones(drive_i) > 1;
    end

    always_comb begin
        // R6
        valid_single_chk: assert (!valid_o || contention_o || $onehot(drive_i))
            else $error("valid without a single driver");
    end
endmodule

// File: rtl/rom_bank_decode.sv
module rom_bank_decode
    import rom_bank_pkg::*;
(
    input  logic [19:0] addr_i,
    input  logic        rd_n_i,
    input  logic        wr_n_i,
    output logic [3:0]  cs_n_o,
    output logic        oe_n_o,
    output logic        we_n_o,
    output logic [14:0] dev_offset_o,
    output logic [7:0]  bus_data_o,
    output logic        bus_valid_o,
    output logic        contention_o
);
    typedef struct packed {
        logic [NBANK-1:0] cs_n;
        logic             oe_n;
        logic             we_n;
        off_t             off;
    } dec_t;

    logic                         hi_ok;
    logic [NBANK-1:0]             cs_n_sel;
    logic [NBANK-1:0]             drv;
    logic [NBANK-1:0][DATA_W-1:0] dev_data;
    dec_t                         dec_d;

    rbd_hi_qual u_hi (
        .top_bits_i (addr_i[ADDR_W-1 -: HI_BITS]),
        .hi_ok_o    (hi_ok)
    );

    rbd_bank_sel u_sel (
        .hi_ok_i (hi_ok),
        .bank_i  (addr_i[OFF_W +: BANK_BITS]),
        .cs_n_o  (cs_n_sel)
    );

    always_comb begin
        dec_d.cs_n = cs_n_sel;
        dec_d.oe_n = rd_n_i;
        dec_d.we_n = wr_n_i;
        dec_d.off  = addr_i[OFF_W-1:0];
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_dev
        rbd_device #(.BANK(g)) u_dev (
            .cs_n_i  (dec_d.cs_n[g]),
            .oe_n_i  (dec_d.oe_n),
            .off_i   (dec_d.off),
            .drive_o (drv[g]),
            .data_o  (dev_data[g])
        );
    end

    rbd_bus_resolve u_res (
        .drive_i      (drv),
        .data_i       (dev_data),
        .data_o       (bus_data_o),
        .valid_o      (bus_valid_o),
        .contention_o (contention_o)
    );

    assign cs_n_o       = dec_d.cs_n;
    assign oe_n_o       = dec_d.oe_n;
    assign we_n_o       = dec_d.we_n;
    assign dev_offset_o = dec_d.off;

    always_comb begin
        // R3
        one_cs_chk: assert ($onehot0(~cs_n_o))
            else $error("more than one chip select active");
        // R6
        drive_gate_chk: assert (!bus_valid_o || (!oe_n_o && !(&cs_n_o)))
            else $error("data driven without chip select and output enable");
        // R10
        no_contention_chk: assert (!contention_o)
            else $error("bus contention");
        // R9
        write_quiet_chk: assert (!(oe_n_o && bus_valid_o))
            else $error("bus driven while read strobe is high");
    end
endmodule

// File: tb/rom_bank_decode_bench.sv
module rom_bank_decode_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [19:0] addr;
    logic        rd_n, wr_n;
    logic [3:0]  cs_n;
    logic        oe_n, we_n, valid, cont;
    logic [14:0] offs;
    logic [7:0]  data;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_bank_decode u_rom_bank_decode (
        .addr_i (addr), .rd_n_i (rd_n), .wr_n_i (wr_n),
        .cs_n_o (cs_n), .oe_n_o (oe_n), .we_n_o (we_n),
        .dev_offset_o (offs), .bus_data_o (data),
        .bus_valid_o (valid), .contention_o (cont)
    );

    function automatic logic [7:0] exp_byte(input int b, input logic [14:0] o);
        return 8'((o[7:0] ^ {1'b0, o[14:8]}) + 64 * b);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [19:0] a, input logic r, input logic w);
        @(negedge clk);
        addr = a; rd_n = r; wr_n = w;
        #1;
    endtask

    task automatic t_reset_idle();
        apply(20'h00000, 1'b1, 1'b1);
        chk("R1 idle cs", {28'd0, cs_n}, 32'hF);
        chk("R8 idle valid", {31'd0, valid}, 0);
        chk("R8 idle data", {24'd0, data}, 0);
    endtask

    task automatic t_low_region();
        logic [19:0] pats [4] = '{20'h1FFFF, 20'hDFFFF, 20'hBABCD, 20'h60000};
        foreach (pats[i]) begin
            apply(pats[i], 1'b0, 1'b1);
            chk("R1 outside region", {28'd0, cs_n}, 32'hF);
            chk("R8 outside valid", {31'd0, valid}, 0);
            chk("R8 outside data", {24'd0, data}, 0);
        end
    endtask

    task automatic t_banks_read();
        for (int b = 0; b < 4; b++) begin
            for (int j = 0; j < 3; j++) begin
                logic [14:0] o;
                o = (j == 0) ? 15'h0000 : (j == 1) ? 15'h7FFF : 15'(16'h1234 * (b + 1));
                apply({3'b111, 2'(b), o}, 1'b0, 1'b1);
                chk("R2 bank cs", {28'd0, cs_n}, 32'(4'hF & ~(4'b1 << b)));
                chk("R3 one cs", $countones(~cs_n), 1);
                chk("R5 offset", {17'd0, offs}, {17'd0, o});
                chk("R6 valid", {31'd0, valid}, 1);
                chk("R7 data", {24'd0, data}, {24'd0, exp_byte(b, o)});
                chk("R10 contention", {31'd0, cont}, 0);
            end
        end
    endtask

    task automatic t_strobes();
        apply(20'hE1234, 1'b1, 1'b0);
        chk("R4 oe", {31'd0, oe_n}, 1);
        chk("R4 we", {31'd0, we_n}, 0);
        chk("R9 write no drive", {31'd0, valid}, 0);
        chk("R8 write data", {24'd0, data}, 0);
        chk("R2 write cs", {28'd0, cs_n}, 32'hE);
        apply(20'h01234, 1'b0, 1'b1);
        chk("R4 oe outside", {31'd0, oe_n}, 0);
        chk("R4 we outside", {31'd0, we_n}, 1);
        chk("R5 offset outside", {17'd0, offs}, 32'h1234);
        apply(20'hF8001, 1'b1, 1'b1);
        chk("R8 no read", {31'd0, valid}, 0);
        chk("R2 bank3 cs", {28'd0, cs_n}, 32'h7);
    endtask

    initial begin
        addr = '0; rd_n = 1'b1; wr_n = 1'b1;
        t_reset_idle();
        t_low_region();
        t_banks_read();
        t_strobes();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule